// File: doc/BRIEF.md
# Blocking Control-Token Channel

This block carries 32-bit control tokens from one producer core to one consumer core. Each core reaches it through a small memory-mapped window of eight words. Each side has a request/ready bus port, and the block holds ready low for as long as the core has to stall.

On the producer side, a write to word 0 queues a token in a 16-entry first-in first-out store. A read of word 0 is a completion barrier. It finishes only once the queue has drained, the consumer is itself parked on a word-0 read, and the consumer's coprocessor reports idle.

On the consumer side, a read of word 0 takes the oldest token and returns it together with a decoded token type. That read stalls while the queue is empty. Reads of word 1 and word 2 turn the external coprocessor-idle and macro-op-expander-done inputs into bus stalls. Words 3 to 7 are reserved.

Top module: `ctl_token_chan`

## Requirements
- R1: A synchronous reset empties the queue, so that afterwards a consumer word-0 read stalls, and no request is answered with ready while reset is high.
- R2: A producer write at word 0 pushes its data. When 16 tokens are queued the write holds ready low until a pop frees a slot, and it is accepted on the next cycle after that pop.
- R3: A consumer read at word 0 returns tokens in push order. Read data is valid in the cycle ready is high. On an empty queue the read holds ready low.
- R4: A push and a pop in the same cycle leave the occupancy unchanged. A push into an empty queue is never lost: a consumer stalled on word 0 gets it in the cycle after the push.
- R5: A producer read at word 0 completes only while the queue is empty, the consumer has a word-0 read pending, and the coprocessor-idle input is high, all at once.
- R6: A consumer read at word 1 holds ready low until the coprocessor-idle input is high.
- R7: A consumer read at word 2 holds ready low until the macro-op-done input is high.
- R8: Words 3 to 7 on either side complete in the cycle they are requested, return zero on read, and ignore writes, so a producer write there adds no token.
- R9: During a word-0 pop, the token-type output equals data bits [31:30]: 2'b10 means jump to the address in the low bits, 2'b01 means resume, 2'b11 means sync, and 2'b00 means start a loop.
- R10: Ready is never high on a port whose request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| p_req | input | 1 | Producer access request |
| p_we | input | 1 | Producer write (1) or read (0) |
| p_addr | input | 3 | Producer word offset |
| p_wdata | input | 32 | Producer write data |
| p_ready | output | 1 | Producer access completes this cycle |
| p_rdata | output | 32 | Producer read data (always zero) |
| c_req | input | 1 | Consumer access request |
| c_we | input | 1 | Consumer write (1) or read (0) |
| c_addr | input | 3 | Consumer word offset |
| c_wdata | input | 32 | Consumer write data (ignored) |
| c_ready | output | 1 | Consumer access completes this cycle |
| c_rdata | output | 32 | Consumer read data |
| c_kind | output | 2 | Decoded type of the popped token |
| cop_idle | input | 1 | Coprocessor thread has no work in flight |
| mop_done | input | 1 | Macro-op expander has finished |

## Verification
A wrong occupancy count shows up at the ports as soon as the queue reaches one of its edges. A count that is too high makes the producer stall early, on the push that should have been the sixteenth. A count that is too low lets a pop return stale data on the empty edge. A pointer that slips shows on the first out-of-order pop, which the bench catches by giving every token a distinct value. A barrier that ignores any one of its three conditions shows within the cycle, because the bench holds exactly one condition false at a time and samples producer ready before the clock edge.

// File: rtl/tokchan_pkg.sv
package tokchan_pkg;

   typedef enum logic [1:0] {
      TK_LOOP   = 2'b00,
      TK_RESUME = 2'b01,
      TK_JUMP   = 2'b10,
      TK_SYNC   = 2'b11
   } tok_kind_e;

   localparam int unsigned WIN_WORDS = 8;
   localparam int unsigned OFS_W     = 3;

   localparam logic [OFS_W-1:0] OFS_QUEUE = 3'd0;
   localparam logic [OFS_W-1:0] OFS_COP   = 3'd1;
   localparam logic [OFS_W-1:0] OFS_MOP   = 3'd2;

   function automatic tok_kind_e kind_of(input logic [1:0] top_bits);
      return tok_kind_e'(top_bits);
   endfunction

endpackage

// File: rtl/tokchan_fifo.sv
module tokchan_fifo #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              full,
   output logic              empty
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = PTR_W + 1;
   localparam bit          POW2  = ((1 << PTR_W) == DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("tokchan_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("tokchan_fifo: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  count;

   if (POW2) begin : g_wrap_natural
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_compare
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
      push |-> (count < CNT_W'(DEPTH)));
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
      pop |-> (count != '0));
   a_r4_count_hold: assert property (@(posedge clk) disable iff (rst)
      (push && pop) |=> (count == $past(count)));
endmodule

// File: rtl/tokchan_prod_port.sv
module tokchan_prod_port
   import tokchan_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              rst,
   input  logic              req,
   input  logic              we,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] wdata,
   input  logic              q_full,
   input  logic              q_empty,
   input  logic              cons_waiting,
   input  logic              cop_idle,
   output logic              ready,
   output logic [DATA_W-1:0] rdata,
   output logic              push,
   output logic [DATA_W-1:0] push_data
);
   always_comb begin
      ready = 1'b0;
      push  = 1'b0;
      if (!rst && req) begin
         if (ofs == OFS_QUEUE) begin
            if (we) begin
               ready = !q_full;
               push  = !q_full;
            end else begin
               ready = q_empty && cons_waiting && cop_idle;
            end
         end else begin
            ready = 1'b1;
         end
      end
   end

   assign push_data = wdata;
   assign rdata     = '0;
endmodule

// File: rtl/tokchan_cons_port.sv
module tokchan_cons_port
   import tokchan_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              rst,
   input  logic              req,
   input  logic              we,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [DATA_W-1:0] q_head,
   input  logic              q_empty,
   input  logic              cop_idle,
   input  logic              mop_done,
   output logic              ready,
   output logic [DATA_W-1:0] rdata,
   output tok_kind_e         kind,
   output logic              pop,
   output logic              waiting
);
   logic rd;
   assign rd = !rst && req && !we;

   always_comb begin
      ready = 1'b0;
      pop   = 1'b0;
      if (!rst && req) begin
         if (we) begin
            ready = 1'b1;
         end else begin
            unique case (ofs)
               OFS_QUEUE: begin
                  ready = !q_empty;
                  pop   = !q_empty;
               end
               OFS_COP: ready = cop_idle;
               OFS_MOP: ready = mop_done;
               default: ready = 1'b1;
            endcase
         end
      end
   end

   assign waiting = rd && (ofs == OFS_QUEUE) && q_empty;
   assign rdata   = pop ? q_head : '0;
   assign kind    = pop ? kind_of(q_head[DATA_W-1 -: 2]) : TK_LOOP;
endmodule

// File: rtl/ctl_token_chan.sv
module ctl_token_chan
   import tokchan_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              p_req,
   input  logic              p_we,
   input  logic [2:0]        p_addr,
   input  logic [DATA_W-1:0] p_wdata,
   output logic              p_ready,
   output logic [DATA_W-1:0] p_rdata,
   input  logic              c_req,
   input  logic              c_we,
   input  logic [2:0]        c_addr,
   input  logic [DATA_W-1:0] c_wdata,
   output logic              c_ready,
   output logic [DATA_W-1:0] c_rdata,
   output logic [1:0]        c_kind,
   input  logic              cop_idle,
   input  logic              mop_done
);
   logic              push, pop, q_full, q_empty, cons_waiting;
   logic [DATA_W-1:0] push_data, q_head;
   tok_kind_e         kind;
   logic              c_wdata_unused;

   assign c_wdata_unused = ^c_wdata;

   tokchan_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
      .head(q_head), .full(q_full), .empty(q_empty)
   );

   tokchan_prod_port #(.DATA_W(DATA_W)) u_prod (
      .rst(rst), .req(p_req), .we(p_we), .ofs(p_addr), .wdata(p_wdata),
      .q_full(q_full), .q_empty(q_empty), .cons_waiting(cons_waiting),
      .cop_idle(cop_idle), .ready(p_ready), .rdata(p_rdata),
      .push(push), .push_data(push_data)
   );

   tokchan_cons_port #(.DATA_W(DATA_W)) u_cons (
      .rst(rst), .req(c_req), .we(c_we), .ofs(c_addr), .q_head(q_head),
      .q_empty(q_empty), .cop_idle(cop_idle), .mop_done(mop_done),
      .ready(c_ready), .rdata(c_rdata), .kind(kind), .pop(pop),
      .waiting(cons_waiting)
   );

   assign c_kind = kind;

   a_r5_barrier: assert property (@(posedge clk) disable iff (rst)
      (p_req && !p_we && p_addr == 3'd0 && p_ready) |->
         (c_req && !c_we && c_addr == 3'd0 && !c_ready && cop_idle));
   a_r6_cop_wait: assert property (@(posedge clk) disable iff (rst)
      (c_req && !c_we && c_addr == 3'd1 && c_ready) |-> cop_idle);
   a_r7_mop_wait: assert property (@(posedge clk) disable iff (rst)
      (c_req && !c_we && c_addr == 3'd2 && c_ready) |-> mop_done);
   a_r9_kind: assert property (@(posedge clk) disable iff (rst)
      (c_req && !c_we && c_addr == 3'd0 && c_ready) |->
         (c_kind == c_rdata[DATA_W-1 -: 2]));
   a_r10_no_idle_ready: assert property (@(posedge clk) disable iff (rst)
      (!p_req |-> !p_ready) and (!c_req |-> !c_ready));
   a_r4_push_seen: assert property (@(posedge clk) disable iff (rst)
      (p_req && p_we && p_addr == 3'd0 && p_ready && !c_ready) |=> !cons_waiting);
endmodule

// File: tb/test_ctl_token_chan.sv
`timescale 1ns/1ps
module test_ctl_token_chan;
   logic        clk = 1'b0;
   logic        rst;
   logic        p_req, p_we, c_req, c_we, cop_idle, mop_done;
   logic [2:0]  p_addr, c_addr;
   logic [31:0] p_wdata, c_wdata, p_rdata, c_rdata;
   logic        p_ready, c_ready;
   logic [1:0]  c_kind;
   int          total = 0, bad = 0;

   always #2.5 clk = ~clk;

   ctl_token_chan i_ctl_token_chan (
      .clk(clk), .rst(rst),
      .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata),
      .p_ready(p_ready), .p_rdata(p_rdata),
      .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
      .c_ready(c_ready), .c_rdata(c_rdata), .c_kind(c_kind),
      .cop_idle(cop_idle), .mop_done(mop_done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic at_neg();
      @(negedge clk);
   endtask

   function automatic logic [31:0] tok(input int i);
      return {2'(i), 30'(i * 37 + 11)};
   endfunction

   task automatic push(input logic [31:0] d);
      at_neg();
      p_req = 1; p_we = 1; p_addr = 0; p_wdata = d;
      #1;
      while (!p_ready) begin at_neg(); #1; end
      @(posedge clk); #1;
      p_req = 0; p_we = 0;
   endtask

   task automatic pop_chk(input logic [31:0] exp, input string tag);
      at_neg();
      c_req = 1; c_we = 0; c_addr = 0;
      #1;
      while (!c_ready) begin at_neg(); #1; end
      chk(c_rdata == exp, tag, c_rdata, exp);
      chk(c_kind == exp[31:30], "R9 kind", {30'd0, c_kind}, {30'd0, exp[31:30]});
      @(posedge clk); #1;
      c_req = 0;
   endtask

   task automatic t_reset();
      at_neg(); rst = 1; at_neg(); at_neg(); rst = 0;
      c_req = 1; c_we = 0; c_addr = 0; cop_idle = 1;
      p_req = 1; p_we = 0; p_addr = 0;
      #1;
      chk(!c_ready, "R1 pop stalls after reset", {31'd0, c_ready}, 0);
      chk(p_ready, "R1 barrier sees empty queue", {31'd0, p_ready}, 1);
      at_neg(); rst = 1; #1;
      chk(!p_ready && !c_ready, "R1 no ready in reset", {30'd0, p_ready, c_ready}, 0);
      at_neg(); rst = 0; p_req = 0; c_req = 0; #1;
      chk(!p_ready && !c_ready, "R10 no ready without req", {30'd0, p_ready, c_ready}, 0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < 16; i++) push(tok(i));
      at_neg();
      p_req = 1; p_we = 1; p_addr = 0; p_wdata = tok(16);
      for (int k = 0; k < 3; k++) begin
         #1; chk(!p_ready, "R2 write stalls when full", {31'd0, p_ready}, 0);
         at_neg();
      end
      c_req = 1; c_we = 0; c_addr = 0; #1;
      chk(c_ready && c_rdata == tok(0), "R3 oldest first", c_rdata, tok(0));
      chk(!p_ready, "R2 still full during pop cycle", {31'd0, p_ready}, 0);
      at_neg(); c_req = 0; #1;
      chk(p_ready, "R2 slot freed", {31'd0, p_ready}, 1);
      @(posedge clk); #1; p_req = 0;
      for (int i = 1; i <= 16; i++) pop_chk(tok(i), "R3 fifo order");
   endtask

   task automatic t_simul();
      push(32'h4000_0001); push(32'hC000_0002); push(32'h8000_0003);
      at_neg();
      p_req = 1; p_we = 1; p_addr = 0; p_wdata = 32'h0000_0004;
      c_req = 1; c_we = 0; c_addr = 0; #1;
      chk(p_ready && c_ready, "R4 push and pop together", {30'd0, p_ready, c_ready}, 3);
      chk(c_rdata == 32'h4000_0001, "R4 pop data", c_rdata, 32'h4000_0001);
      @(posedge clk); #1; p_req = 0; c_req = 0;
      pop_chk(32'hC000_0002, "R4 order after simul");
      pop_chk(32'h8000_0003, "R4 order after simul");
      pop_chk(32'h0000_0004, "R4 pushed token kept");
      at_neg(); c_req = 1; c_we = 0; c_addr = 0; #1;
      chk(!c_ready, "R4 count unchanged, now empty", {31'd0, c_ready}, 0);
      at_neg(); #1;
      chk(!c_ready, "R3 empty read stalls", {31'd0, c_ready}, 0);
      p_req = 1; p_we = 1; p_addr = 0; p_wdata = 32'h8123_4567;
      @(posedge clk); #1; p_req = 0;
      at_neg(); #1;
      chk(c_ready && c_rdata == 32'h8123_4567, "R4 push into empty not lost", c_rdata, 32'h8123_4567);
      chk(c_kind == 2'b10, "R9 jump kind", {30'd0, c_kind}, 2);
      @(posedge clk); #1; c_req = 0;
   endtask

   task automatic t_barrier();
      push(32'h0000_00AA);
      cop_idle = 1;
      at_neg(); p_req = 1; p_we = 0; p_addr = 0; #1;
      chk(!p_ready, "R5 blocks while queue holds token", {31'd0, p_ready}, 0);
      p_req = 0;
      pop_chk(32'h0000_00AA, "R5 drain");
      at_neg(); p_req = 1; p_we = 0; p_addr = 0; #1;
      chk(!p_ready, "R5 blocks without consumer wait", {31'd0, p_ready}, 0);
      at_neg(); cop_idle = 0; c_req = 1; c_we = 0; c_addr = 0; #1;
      chk(!p_ready, "R5 blocks while coprocessor busy", {31'd0, p_ready}, 0);
      at_neg(); cop_idle = 1; #1;
      chk(p_ready, "R5 completes with all three", {31'd0, p_ready}, 1);
      chk(p_rdata == 0, "R5 barrier data", p_rdata, 0);
      at_neg(); c_addr = 3'd1; p_req = 0; #1;
      chk(!p_ready, "R10 no ready after req drop", {31'd0, p_ready}, 0);
      c_req = 0;
   endtask

   task automatic t_status();
      at_neg(); cop_idle = 0; mop_done = 0;
      c_req = 1; c_we = 0; c_addr = 3'd1; #1;
      chk(!c_ready, "R6 word1 waits for idle", {31'd0, c_ready}, 0);
      at_neg(); mop_done = 1; #1;
      chk(!c_ready, "R6 word1 ignores mop_done", {31'd0, c_ready}, 0);
      at_neg(); cop_idle = 1; #1;
      chk(c_ready, "R6 word1 completes", {31'd0, c_ready}, 1);
      at_neg(); c_addr = 3'd2; mop_done = 0; #1;
      chk(!c_ready, "R7 word2 waits for done", {31'd0, c_ready}, 0);
      at_neg(); mop_done = 1; #1;
      chk(c_ready, "R7 word2 completes", {31'd0, c_ready}, 1);
      at_neg(); c_req = 0;
   endtask

   task automatic t_reserved();
      for (int a = 3; a < 8; a++) begin
         at_neg(); p_req = 1; p_we = 1; p_addr = 3'(a); p_wdata = 32'hDEAD_0000 + 32'(a); #1;
         chk(p_ready, "R8 reserved write completes", {31'd0, p_ready}, 1);
         at_neg(); p_we = 0; c_req = 1; c_we = 0; c_addr = 3'(a); #1;
         chk(p_ready && p_rdata == 0, "R8 producer reserved read", p_rdata, 0);
         chk(c_ready && c_rdata == 0, "R8 consumer reserved read", c_rdata, 0);
         at_neg(); p_req = 0; c_req = 0;
      end
      at_neg(); c_req = 1; c_we = 0; c_addr = 0; #1;
      chk(!c_ready, "R8 reserved writes added no token", {31'd0, c_ready}, 0);
      at_neg(); c_req = 0;
   endtask

   initial begin
      rst = 1; p_req = 0; p_we = 0; p_addr = 0; p_wdata = 0;
      c_req = 0; c_we = 0; c_addr = 0; c_wdata = 0; cop_idle = 0; mop_done = 0;
      t_reset();
      t_fill();
      t_simul();
      t_barrier();
      t_status();
      t_reserved();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      total++; bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule